// File: doc/BRIEF.md
# Interrupting Capture Slave

This block is an I/O-space slave on a 32-bit address and 32-bit data bus. An external source hands it a 32-bit word with a one-cycle valid strobe. The block latches the word into its data register and raises an interrupt request.

A bus master reads two read-only locations. One returns the captured word. The other returns a fixed interrupt number, which the master uses to find its service routine. Reading the data register is the event that drops the request. The block answers only when the space-select line marks I/O space. It ignores bus writes.

Read data is combinational within the bus cycle, and a read-enable flag marks when the block drives it. The data register and the request flag are updated on the rising clock edge.

Top module: `irqslv_top`

## Requirements
- R1: After reset the interrupt output is 0 and the data register holds 0.
- R2: A read (bus_rd=1, bus_wr=0) in I/O space (bus_mem=0) at address 0x00002000 returns the last captured word on rd_data with rd_en=1, in the same cycle.
- R3: A read in I/O space at address 0x00002004 returns 0x00000003 with rd_en=1.
- R4: With bus_mem=1 the block never drives: rd_en=0 and rd_data=0, and such a read does not clear the interrupt.
- R5: When no read is decoded (any other address, bus_rd=0, or bus_wr=1), rd_en=0 and rd_data=0.
- R6: A cycle with ext_valid=1 captures ext_data and sets irq on the following clock edge.
- R7: An I/O-space read of 0x00002000 with no capture in the same cycle clears irq on the following edge.
- R8: A capture while irq is already set overwrites the data register, and irq stays 1.
- R9: When a capture and a data-register read fall in the same cycle, the read returns the previous word, the new word is stored, and irq stays 1.
- R10: Bus writes to either address change neither the data register nor irq.
- R11: Reading the interrupt-number register leaves irq unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_mem | input | 1 | Space select: 1 memory, 0 I/O |
| rd_data | output | 32 | Read data, zero when not driving |
| rd_en | output | 1 | Block is driving rd_data |
| ext_valid | input | 1 | External word valid strobe |
| ext_data | input | 32 | External word |
| irq | output | 1 | Interrupt request |

## Verification
Two events can meet in one cycle: a new external word arriving and the master reading the data register. The first sets the request and the second clears it. The bench provokes this collision on purpose in directed steps, and the random stimulus also brings it about often. A cycle is judged correct when the bus sees the old word in that cycle, irq is still high after the edge, and a later read returns the new word.

// File: rtl/irqslv_pkg.sv
package irqslv_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_DATA = 2'd1,
    RSEL_VEC  = 2'd2
  } rsel_e;
endpackage

// File: rtl/irqslv_decode.sv
module irqslv_decode
  import irqslv_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] DATA_ADDR = 32'h0000_2000,
  parameter logic [AW-1:0] VEC_ADDR  = 32'h0000_2004
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic          mem_space,
  output rsel_e         sel,
  output logic          data_read
);
  function automatic rsel_e decode_sel(input logic [AW-1:0] a, input logic r,
                                       input logic w, input logic m);
    if (!r || w || m)       return RSEL_NONE;
    if (a == DATA_ADDR)     return RSEL_DATA;
    if (a == VEC_ADDR)      return RSEL_VEC;
    return RSEL_NONE;
  endfunction

  always_comb begin
    sel       = decode_sel(addr, rd, wr, mem_space);
    data_read = (sel == RSEL_DATA);
  end

  // R7: the clearing event only comes from an I/O read strobe
  assert_read_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_read |-> (rd && !mem_space && !wr));
endmodule

// File: rtl/irqslv_capture.sv
module irqslv_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_valid,
  input  logic [DW-1:0] ext_data,
  output logic [DW-1:0] data_q,
  output logic          capture_evt
);
  assign capture_evt = ext_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)         data_q <= '0;
    else if (ext_valid) data_q <= ext_data;
  end

  // R10: nothing but a capture alters the stored word
  assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_valid |=> $stable(data_q));
  // R6: a capture lands the external word
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |=> (data_q == $past(ext_data)));
endmodule

// File: rtl/irqslv_irq.sv
module irqslv_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_evt,
  input  logic data_read,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)           irq <= 1'b0;
    else if (capture_evt) irq <= 1'b1;   // arrival outranks the read (R9)
    else if (data_read)   irq <= 1'b0;
  end

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> irq);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_read && !capture_evt) |=> !irq);
  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !data_read) |=> irq);
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !capture_evt) |=> !irq);
endmodule

// File: rtl/irqslv_top.sv
module irqslv_top
  import irqslv_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] DATA_ADDR = 32'h0000_2000,
  parameter logic [AW-1:0] VEC_ADDR  = 32'h0000_2004,
  parameter logic [DW-1:0] IRQ_NUM   = 32'h0000_0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          bus_mem,
  output logic [DW-1:0] rd_data,
  output logic          rd_en,
  input  logic          ext_valid,
  input  logic [DW-1:0] ext_data,
  output logic          irq
);
  rsel_e         sel;
  logic          data_read;
  logic          capture_evt;
  logic [DW-1:0] data_q;

  function automatic logic [DW-1:0] rd_mux(input rsel_e s, input logic [DW-1:0] d);
    case (s)
      RSEL_DATA: return d;
      RSEL_VEC:  return IRQ_NUM;
      default:   return '0;
    endcase
  endfunction

  irqslv_decode #(.AW(AW), .DATA_ADDR(DATA_ADDR), .VEC_ADDR(VEC_ADDR)) u_decode (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .mem_space(bus_mem), .sel(sel), .data_read(data_read)
  );

  irqslv_capture #(.DW(DW)) u_capture (
    .clk(clk), .rst_n(rst_n), .ext_valid(ext_valid), .ext_data(ext_data),
    .data_q(data_q), .capture_evt(capture_evt)
  );

  irqslv_irq u_irq (
    .clk(clk), .rst_n(rst_n), .capture_evt(capture_evt),
    .data_read(data_read), .irq(irq)
  );

  always_comb begin
    rd_en   = (sel != RSEL_NONE);
    rd_data = rd_mux(sel, data_q);
  end

  assert_mem_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mem |-> (!rd_en && rd_data == '0));
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
  assert_vec_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == VEC_ADDR) |-> (rd_data == IRQ_NUM));
  assert_drive_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (bus_rd && !bus_wr));
endmodule

// File: tb/test_irqslv_top.sv
module test_irqslv_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] A_DATA = 32'h0000_2000;
  localparam logic [31:0] A_VEC  = 32'h0000_2004;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] bus_addr = '0, ext_data = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, bus_mem = 1'b0, ext_valid = 1'b0;
  logic [31:0] rd_data;
  logic rd_en, irq;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_data = '0;
  logic m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqslv_top i_irqslv_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_mem(bus_mem), .rd_data(rd_data), .rd_en(rd_en),
    .ext_valid(ext_valid), .ext_data(ext_data), .irq(irq)
  );

  function automatic logic exp_en(logic [31:0] a, logic r, logic w, logic m);
    return r && !w && !m && (a == A_DATA || a == A_VEC);
  endfunction

  function automatic logic [31:0] exp_rd(logic [31:0] a, logic r, logic w,
                                         logic m, logic [31:0] d);
    if (!exp_en(a, r, w, m)) return 32'h0;
    return (a == A_DATA) ? d : 32'h3;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus/capture cycle: drive at negedge, check read side, then the edge
  task automatic cyc(string tag, logic [31:0] a, logic r, logic w, logic m,
                     logic xv, logic [31:0] xd);
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_mem = m;
    ext_valid = xv; ext_data = xd;
    #1;
    check({tag, " rd_en"}, {31'b0, rd_en}, {31'b0, exp_en(a, r, w, m)});
    check({tag, " rd_data"}, rd_data, exp_rd(a, r, w, m, m_data));
    @(posedge clk);
    if (xv) begin m_data = xd; m_irq = 1'b1; end
    else if (r && !w && !m && a == A_DATA) m_irq = 1'b0;
    #1;
    check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic idle();
    cyc("idle", 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed_use;
    seed_use = $urandom(32'd1729);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 irq", {31'b0, irq}, 32'h0);
    cyc("R1 data", A_DATA, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    cyc("R3 vec", A_VEC, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    cyc("R6 capture", 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hCAFE_0001);
    cyc("R11 vec keeps irq", A_VEC, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    cyc("R4 mem read", A_DATA, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0);
    cyc("R10 write data", A_DATA, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
    cyc("R10 write+read", A_DATA, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
    cyc("R5 other addr", 32'h0000_3000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    cyc("R8 overwrite", 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1234_5678);
    cyc("R9 collide", A_DATA, 1'b1, 1'b0, 1'b0, 1'b1, 32'hBEEF_0002);
    cyc("R2 read new", A_DATA, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    cyc("R7 cleared reread", A_DATA, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    idle();
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [1:0] pick;
      pick = 2'($urandom_range(0, 3));
      case (pick)
        2'd0: a = A_DATA;
        2'd1: a = A_VEC;
        2'd2: a = 32'h0000_3000;
        default: a = $urandom();
      endcase
      cyc("R2/R3/R5/R7/R9 random", a, 1'($urandom_range(0, 1)),
          ($urandom_range(0, 5) == 0), ($urandom_range(0, 4) == 0),
          ($urandom_range(0, 3) == 0), $urandom());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule